// File: doc/BRIEF.md
# Triggered Stream Capture Buffer

This block takes a stream of data words, qualified by a valid strobe and marked by a sync strobe, and stores a window of valid words in an internal buffer. A host reads that buffer through a simple read port, and it reaches a small bank of 32-bit registers through a separate register port. The block starts a capture in one of three ways. With the sync-use parameter clear, it fills once from reset and refills only after the host has read the highest buffer address. With the parameter set and a sync delay of zero, every sync pulse starts a new fill. With a nonzero delay, each fill must be armed by the host and starts a programmable number of valid words after the next sync.

The register bank reports three counts: sync pulses seen since the last full readout, words stored in the current capture, and valid cycles since the most recent sync. It also holds the sync delay and a fixed version word. All logic runs on one clock. Both read paths have one cycle of latency.

Top module: `snap_buffer`

## Requirements
- R1: After reset, every register reads zero except the version word. `reg_rdata` is zero until the first register read.
- R2: With `USE_SYNC`=0, from reset the first `DEPTH` cycles with `st_valid` high store their data at buffer addresses 0, 1, 2 and so on in arrival order. Cycles with `st_valid` low store nothing. Once `DEPTH` words are stored, no further word is stored.
- R3: With `USE_SYNC`=0, a buffer read (`buf_rd` high) of address `DEPTH`-1 restarts the capture: the word count returns to 0, and new valid words fill from address 0 again. A valid word in the same cycle as that read is stored as word 0.
- R4: With `USE_SYNC`=1 and a sync delay of 0, nothing is stored before the first sync. Every cycle with `st_sync` high starts a new capture. The valid word in that cycle, if present, is word 0. Addresses that the new capture has not yet reached keep their old data.
- R5: With `USE_SYNC`=1 and a nonzero sync delay D, a sync starts a capture only if the host armed the block before it. The host arms the block by writing any value to register index 2. After the triggering sync, the first D valid words are skipped, counting the sync cycle's own valid word. The next `DEPTH` valid words are stored. Later syncs have no effect until the block is armed again.
- R6: Register index 1 reads the number of words stored in the current capture. It is cleared when a capture starts and never exceeds `DEPTH`.
- R7: Register index 0 counts the cycles with `st_sync` high. A buffer read of address `DEPTH`-1 clears it. A sync in that same cycle leaves it at 1.
- R8: Register index 2 reads the number of valid cycles since the last sync. A sync cycle sets it to 1 if `st_valid` is high and to 0 otherwise.
- R9: A register read (`reg_rd` high) shows the value on `reg_rdata` in the next cycle, and `reg_rdata` holds between reads. Index 3 is the sync delay, which can be written and read back. Writes to indices 0, 1 and 4 to 7 change nothing.
- R10: Register indices 4, 5 and 6 read zero. Index 7 reads the `VERSION` parameter.
- R11: A buffer read returns the stored word at `buf_addr` on `buf_rdata` in the next cycle. Reads of addresses below `DEPTH`-1 never pause or disturb a capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Stream word qualifier |
| st_data | input | DATA_W | Stream word |
| st_sync | input | 1 | Stream sync strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| buf_rd | input | 1 | Buffer read strobe |
| buf_addr | input | log2(DEPTH) | Buffer read address |
| buf_rdata | output | DATA_W | Buffer read data, one cycle after `buf_rd` |

## Verification
In the free-running variant, a stream with gaps between valid words shows that only qualified words are kept and that they land in order. Pushing more words than the buffer holds shows where storing stops. A sync stream that begins with unsynchronised words, followed by two syncs of different lengths, separates an overwrite from the start from one that leaves the tail untouched. In armed mode, one sync arrives before arming, one after arming, and one after the capture has finished. A final armed sync carries no valid word, which pins down how the skip count treats the trigger cycle. Counter tests combine a sync with a last-address read in the same cycle to show which of the two takes priority.

// File: rtl/snap_pkg.sv
package snap_pkg;

   // host register bank geometry
   localparam int REG_W  = 32;
   localparam int REG_AW = 3;

   // register indices; the host map depends on these positions
   typedef enum logic [REG_AW-1:0] {
      RIX_SYNCS  = 3'd0,
      RIX_WORDS  = 3'd1,
      RIX_VALIDS = 3'd2,
      RIX_DELAY  = 3'd3,
      RIX_VER    = 3'd7
   } reg_ix_e;

endpackage

// File: rtl/snap_mem.sv
module snap_mem #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [DATA_W-1:0]        rd_data
);

   logic [DATA_W-1:0] cells [DEPTH];

   // one write port for the stream, one registered read port for the host
   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
      if (rd_en) rd_data <= cells[rd_addr];
   end

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl import snap_pkg::*; #(
   parameter int DEPTH    = 1024,
   parameter bit USE_SYNC = 1'b1,
   parameter int CNT_W    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sync,
   input  logic [REG_W-1:0]         sync_dly,
   input  logic                     arm_req,
   input  logic                     last_rd,
   output logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_addr,
   output logic [CNT_W-1:0]         word_cnt,
   output logic [CNT_W-1:0]         sync_cnt,
   output logic [CNT_W-1:0]         valid_cnt
);

   localparam int AW = $clog2(DEPTH);
   localparam int FW = AW + 1;

   logic [FW-1:0]    fill;       // words stored in this capture
   logic             opened;     // a capture has been started at least once
   logic [REG_W-1:0] skip_left;  // valid words still to skip
   logic             start;      // capture (re)starts this cycle
   logic [REG_W-1:0] skip_load;  // skip count loaded at start
   logic [REG_W-1:0] skip_eff;
   logic [FW-1:0]    fill_eff;
   logic             store;

   generate
      if (USE_SYNC == 1'b0) begin : g_free
         // refill after the host has drained the top address
         logic unused_arm_path;
         assign unused_arm_path = ^{arm_req, sync_dly};
         assign start     = last_rd;
         assign skip_load = '0;
      end else begin : g_sync
         logic armed;
         // zero delay: every sync; nonzero delay: only an armed sync
         assign start     = in_sync && ((sync_dly == '0) || armed);
         assign skip_load = sync_dly;
         always_ff @(posedge clk) begin
            if (!rst_n)       armed <= 1'b0;
            else if (arm_req) armed <= 1'b1;
            else if (start)   armed <= 1'b0;
         end
      end
   endgenerate

   // the trigger cycle already acts on the freshly loaded state
   always_comb begin
      fill_eff = start ? '0 : fill;
      skip_eff = start ? skip_load : skip_left;
      store    = in_valid && (start || opened) && (skip_eff == '0)
                 && (fill_eff < FW'(DEPTH));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill      <= '0;
         opened    <= (USE_SYNC == 1'b0);
         skip_left <= '0;
      end else begin
         if (start) opened <= 1'b1;
         fill      <= fill_eff + FW'(store);
         skip_left <= (in_valid && (skip_eff != '0)) ? skip_eff - REG_W'(1) : skip_eff;
      end
   end

   // status counters with their own clear events
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_cnt  <= '0;
         valid_cnt <= '0;
      end else begin
         sync_cnt  <= (last_rd ? '0 : sync_cnt) + CNT_W'(in_sync);
         valid_cnt <= (in_sync ? '0 : valid_cnt) + CNT_W'(in_valid);
      end
   end

   assign wr_en    = store;
   assign wr_addr  = fill_eff[AW-1:0];
   assign word_cnt = CNT_W'(fill);

endmodule

// File: rtl/snap_regs.sv
module snap_regs import snap_pkg::*; #(
   parameter int              CNT_W   = 32,
   parameter logic [REG_W-1:0] VERSION = 32'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic [CNT_W-1:0]  sync_cnt,
   input  logic [CNT_W-1:0]  word_cnt,
   input  logic [CNT_W-1:0]  valid_cnt,
   output logic [REG_W-1:0]  sync_dly,
   output logic              arm_req,
   output logic [REG_W-1:0]  reg_rdata
);

   logic [REG_W-1:0] rd_mux;

   // a write to the valid-count index arms the trigger
   assign arm_req = reg_wr && (reg_addr == RIX_VALIDS);

   always_comb begin
      case (reg_addr)
         RIX_SYNCS:  rd_mux = REG_W'(sync_cnt);
         RIX_WORDS:  rd_mux = REG_W'(word_cnt);
         RIX_VALIDS: rd_mux = REG_W'(valid_cnt);
         RIX_DELAY:  rd_mux = sync_dly;
         RIX_VER:    rd_mux = VERSION;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_dly  <= '0;
         reg_rdata <= '0;
      end else begin
         if (reg_wr && (reg_addr == RIX_DELAY)) sync_dly <= reg_wdata;
         if (reg_rd) reg_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/snap_buffer.sv
module snap_buffer import snap_pkg::*; #(
   parameter int               DATA_W   = 32,
   parameter int               DEPTH    = 1024,
   parameter bit               USE_SYNC = 1'b1,
   parameter int               CNT_W    = 32,
   parameter logic [REG_W-1:0] VERSION  = 32'h1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     st_valid,
   input  logic [DATA_W-1:0]        st_data,
   input  logic                     st_sync,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [REG_AW-1:0]        reg_addr,
   input  logic [REG_W-1:0]         reg_wdata,
   output logic [REG_W-1:0]         reg_rdata,
   input  logic                     buf_rd,
   input  logic [$clog2(DEPTH)-1:0] buf_addr,
   output logic [DATA_W-1:0]        buf_rdata
);

   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("snap_buffer: DEPTH must be a power of two, at least 2");
      end
      if (CNT_W < AW + 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("snap_buffer: CNT_W must cover DEPTH and fit a register");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("snap_buffer: DATA_W must be positive");
      end
   endgenerate

   logic             last_rd;
   logic             mem_we;
   logic [AW-1:0]    mem_waddr;
   logic [CNT_W-1:0] word_cnt;
   logic [CNT_W-1:0] sync_cnt;
   logic [CNT_W-1:0] valid_cnt;
   logic [REG_W-1:0] sync_dly;
   logic             arm_req;

   assign last_rd = buf_rd && (buf_addr == AW'(DEPTH - 1));

   snap_ctrl #(
      .DEPTH    (DEPTH),
      .USE_SYNC (USE_SYNC),
      .CNT_W    (CNT_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (st_valid),
      .in_sync   (st_sync),
      .sync_dly  (sync_dly),
      .arm_req   (arm_req),
      .last_rd   (last_rd),
      .wr_en     (mem_we),
      .wr_addr   (mem_waddr),
      .word_cnt  (word_cnt),
      .sync_cnt  (sync_cnt),
      .valid_cnt (valid_cnt)
   );

   snap_mem #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_mem (
      .clk     (clk),
      .wr_en   (mem_we),
      .wr_addr (mem_waddr),
      .wr_data (st_data),
      .rd_en   (buf_rd),
      .rd_addr (buf_addr),
      .rd_data (buf_rdata)
   );

   snap_regs #(
      .CNT_W   (CNT_W),
      .VERSION (VERSION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .sync_cnt  (sync_cnt),
      .word_cnt  (word_cnt),
      .valid_cnt (valid_cnt),
      .sync_dly  (sync_dly),
      .arm_req   (arm_req),
      .reg_rdata (reg_rdata)
   );

endmodule

// File: rtl/snap_buffer_chk.sv
module snap_buffer_chk #(
   parameter int          DEPTH   = 1024,
   parameter int          CNT_W   = 32,
   parameter logic [31:0] VERSION = 32'h1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_sync,
   input logic                     reg_rd,
   input logic [2:0]               reg_addr,
   input logic [31:0]              reg_rdata,
   input logic                     ram_rd,
   input logic [$clog2(DEPTH)-1:0] ram_addr,
   input logic                     wr_en,
   input logic [CNT_W-1:0]         word_cnt,
   input logic [CNT_W-1:0]         sync_cnt,
   input logic [CNT_W-1:0]         valid_cnt
);

   localparam int AW = $clog2(DEPTH);

   p_fill_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      word_cnt <= CNT_W'(DEPTH));

   p_store_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> word_cnt != '0);

   p_word_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (word_cnt == $past(word_cnt)) || (word_cnt <= CNT_W'(1))
               || (word_cnt == $past(word_cnt) + CNT_W'(1)));

   p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd && ram_addr == AW'(DEPTH - 1) && !in_sync) |=> sync_cnt == '0);

   p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sync |=> (sync_cnt == '0) || $stable(sync_cnt));

   p_valid_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && !in_valid) |=> valid_cnt == '0);

   p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr >= 3'd4 && reg_addr <= 3'd6) |=> reg_rdata == '0);

   p_version_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd7) |=> reg_rdata == VERSION);

endmodule

bind snap_buffer snap_buffer_chk #(
   .DEPTH   (DEPTH),
   .CNT_W   (CNT_W),
   .VERSION (VERSION)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (st_valid),
   .in_sync   (st_sync),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .ram_rd    (buf_rd),
   .ram_addr  (buf_addr),
   .wr_en     (mem_we),
   .word_cnt  (word_cnt),
   .sync_cnt  (sync_cnt),
   .valid_cnt (valid_cnt)
);

// File: tb/snap_buffer_tb.sv
module snap_buffer_tb;

   localparam int          DEPTH = 8;
   localparam int          DW    = 16;
   localparam int          AW    = 3;
   localparam logic [31:0] VER   = 32'h0000_0203;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          st_valid = 1'b0;
   logic          st_sync  = 1'b0;
   logic [DW-1:0] st_data  = '0;
   logic          reg_wr   = 1'b0;
   logic          reg_rd   = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic          buf_rd   = 1'b0;
   logic [AW-1:0] buf_addr = '0;

   logic [31:0]   s_rdata, n_rdata;
   logic [DW-1:0] s_bdata, n_bdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // triggered variant
   snap_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .USE_SYNC(1'b1), .VERSION(VER)) u_dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_data(st_data), .st_sync(st_sync),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(s_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(s_bdata));

   // free-running variant
   snap_buffer #(.DATA_W(DW), .DEPTH(DEPTH), .USE_SYNC(1'b0), .VERSION(VER)) u_dut_free (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_data(st_data), .st_sync(st_sync),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(n_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(n_bdata));

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic step(input logic v, input logic [DW-1:0] d, input logic s);
      st_valid = v; st_data = d; st_sync = s;
      @(negedge clk);
      st_valid = 1'b0; st_sync = 1'b0;
   endtask

   task automatic rd_reg(input bit sdut, input logic [2:0] a, output logic [31:0] v);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      v = sdut ? s_rdata : n_rdata;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_buf(input bit sdut, input logic [AW-1:0] a, output logic [DW-1:0] v);
      buf_rd = 1'b1; buf_addr = a;
      @(negedge clk);
      buf_rd = 1'b0;
      v = sdut ? s_bdata : n_bdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      check("R1 rdata before any read", s_rdata, 32'h0);
      for (int i = 0; i < 4; i++) begin
         rd_reg(1'b1, 3'(i), v);
         check($sformatf("R1 sync dut reg %0d", i), v, 32'h0);
         rd_reg(1'b0, 3'(i), v);
         check($sformatf("R1 free dut reg %0d", i), v, 32'h0);
      end
   endtask

   task automatic t_free();
      logic [31:0] v;
      logic [DW-1:0] d;
      do_reset();
      for (int i = 0; i < 10; i++) begin
         step(1'b1, DW'(100 + i), 1'b0);
         if (i % 2 == 0) step(1'b0, 16'hdead, 1'b0);
      end
      rd_reg(1'b0, 3'd1, v);
      check("R2 R6 word count stops at depth", v, 32'd8);
      for (int a = 0; a < DEPTH; a++) begin
         rd_buf(1'b0, AW'(a), d);
         check($sformatf("R2 stored word %0d", a), 32'(d), 32'(100 + a));
      end
      rd_reg(1'b0, 3'd1, v);
      check("R3 word count cleared by last read", v, 32'd0);
      for (int i = 0; i < 3; i++) step(1'b1, DW'(200 + i), 1'b0);
      rd_reg(1'b0, 3'd1, v);
      check("R3 refill word count", v, 32'd3);
      rd_buf(1'b0, AW'(1), d);
      check("R11 read during capture", 32'(d), 32'd201);
      rd_buf(1'b0, AW'(3), d);
      check("R3 untouched old word", 32'(d), 32'd103);
      step(1'b1, DW'(203), 1'b0);
      step(1'b1, DW'(204), 1'b0);
      rd_reg(1'b0, 3'd1, v);
      check("R11 capture continues after read", v, 32'd5);
      rd_buf(1'b0, AW'(4), d);
      check("R11 word after read", 32'(d), 32'd204);
   endtask

   task automatic t_sync();
      logic [31:0] v;
      logic [DW-1:0] d;
      do_reset();
      for (int i = 1; i <= 5; i++) step(1'b1, DW'(i), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R4 nothing before first sync", v, 32'd0);
      step(1'b1, DW'(300), 1'b1);
      for (int i = 301; i <= 309; i++) step(1'b1, DW'(i), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R4 R6 full after sync", v, 32'd8);
      rd_buf(1'b1, AW'(0), d);
      check("R4 sync word is word 0", 32'(d), 32'd300);
      rd_buf(1'b1, AW'(7), d);
      check("R4 last word", 32'(d), 32'd307);
      step(1'b1, DW'(400), 1'b1);
      step(1'b1, DW'(401), 1'b0);
      step(1'b1, DW'(402), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R6 cleared on new sync", v, 32'd3);
      rd_buf(1'b1, AW'(0), d);
      check("R4 overwrite word 0", 32'(d), 32'd400);
      rd_buf(1'b1, AW'(2), d);
      check("R4 overwrite word 2", 32'(d), 32'd402);
      rd_buf(1'b1, AW'(3), d);
      check("R4 tail keeps old data", 32'(d), 32'd303);
   endtask

   task automatic t_arm();
      logic [31:0] v;
      logic [DW-1:0] d;
      do_reset();
      wr_reg(3'd3, 32'd2);
      rd_reg(1'b1, 3'd3, v);
      check("R9 delay readback", v, 32'd2);
      step(1'b1, DW'(500), 1'b1);
      for (int i = 501; i <= 503; i++) step(1'b1, DW'(i), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R5 unarmed sync ignored", v, 32'd0);
      wr_reg(3'd2, 32'd0);
      step(1'b1, DW'(600), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R5 armed waits for sync", v, 32'd0);
      step(1'b1, DW'(610), 1'b1);
      for (int i = 611; i <= 620; i++) step(1'b1, DW'(i), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R5 armed capture full", v, 32'd8);
      rd_buf(1'b1, AW'(0), d);
      check("R5 first word after skip", 32'(d), 32'd612);
      rd_buf(1'b1, AW'(7), d);
      check("R5 last word after skip", 32'(d), 32'd619);
      step(1'b1, DW'(700), 1'b1);
      step(1'b1, DW'(701), 1'b0);
      step(1'b1, DW'(702), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R5 no recapture without rearm", v, 32'd8);
      rd_buf(1'b1, AW'(0), d);
      check("R5 data kept without rearm", 32'(d), 32'd612);
      wr_reg(3'd2, 32'd1);
      step(1'b0, DW'(0), 1'b1);
      for (int i = 800; i <= 803; i++) step(1'b1, DW'(i), 1'b0);
      rd_reg(1'b1, 3'd1, v);
      check("R5 skip counts valid words only", v, 32'd2);
      rd_buf(1'b1, AW'(0), d);
      check("R5 first word after empty sync", 32'(d), 32'd802);
   endtask

   task automatic t_counts();
      logic [31:0] v;
      logic [DW-1:0] d;
      do_reset();
      step(1'b1, DW'(1), 1'b1);
      for (int i = 0; i < 3; i++) step(1'b1, DW'(2), 1'b0);
      step(1'b0, DW'(0), 1'b0);
      step(1'b0, DW'(0), 1'b0);
      step(1'b0, DW'(0), 1'b1);
      step(1'b1, DW'(3), 1'b0);
      step(1'b1, DW'(4), 1'b0);
      rd_reg(1'b1, 3'd0, v);
      check("R7 sync count sync dut", v, 32'd2);
      rd_reg(1'b0, 3'd0, v);
      check("R7 sync count free dut", v, 32'd2);
      rd_reg(1'b1, 3'd2, v);
      check("R8 valid count after empty sync", v, 32'd2);
      rd_buf(1'b1, AW'(DEPTH - 1), d);
      rd_reg(1'b1, 3'd0, v);
      check("R7 cleared by last read", v, 32'd0);
      buf_rd = 1'b1; buf_addr = AW'(DEPTH - 1); st_sync = 1'b1; st_valid = 1'b1;
      @(negedge clk);
      buf_rd = 1'b0; st_sync = 1'b0; st_valid = 1'b0;
      rd_reg(1'b1, 3'd0, v);
      check("R7 sync with clear counts one", v, 32'd1);
      rd_reg(1'b1, 3'd2, v);
      check("R8 valid sync counts one", v, 32'd1);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      do_reset();
      wr_reg(3'd5, 32'hffff_ffff);
      wr_reg(3'd0, 32'd55);
      wr_reg(3'd1, 32'd77);
      for (int i = 4; i <= 6; i++) begin
         rd_reg(1'b1, 3'(i), v);
         check($sformatf("R10 reserved %0d", i), v, 32'h0);
      end
      rd_reg(1'b1, 3'd0, v);
      check("R9 write to sync count ignored", v, 32'd0);
      rd_reg(1'b1, 3'd1, v);
      check("R9 write to word count ignored", v, 32'd0);
      rd_reg(1'b1, 3'd3, v);
      check("R9 other writes leave delay", v, 32'd0);
      rd_reg(1'b1, 3'd7, v);
      check("R10 version sync dut", v, VER);
      rd_reg(1'b0, 3'd7, v);
      check("R10 version free dut", v, VER);
      @(negedge clk);
      check("R9 rdata holds between reads", n_rdata, VER);
   endtask

   initial begin
      t_reset();
      t_free();
      t_sync();
      t_arm();
      t_counts();
      t_regs();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got hang expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule